// File: doc/BRIEF.md
# Multithreaded Issue Slot Allocator

This block decides, once per clock, which decoded instructions from up to eight hardware contexts leave their windows and take one of the core's issue slots. Each context shows an eight-entry in-order window. Each entry carries a ready bit and a two-bit functional-unit class. Readiness is computed elsewhere and arrives as an input. The allocator visits contexts in fixed priority order, with context 0 first. For each context it takes the oldest ready instructions until one of four limits stops it: the per-context cap set by the issue policy, the capacity of the unit class, the total slot width, or a blocked instruction.

A three-bit policy input selects how the contexts share the slots. One policy lets a single context issue per cycle. One lets all contexts compete without a cap. Three policies cap each context at 1, 2 or 4 instructions. The last binds each context to one unit class, chosen by a per-context binding input. The results are registered. They are presented both as a grant bit per window entry and as a packed list of issue slots, each slot tagged with its context, window entry and unit class.

Top module: `smt_issue_alloc`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, every grant bit and every slot valid bit is 0, and every slot tag is 0.
- R2: A window entry is granted only if it is ready. Within one context the granted entries always form an unbroken run starting at entry 0: the first entry that is not granted ends that context's issue for the cycle.
- R3: Class codes are 0 integer, 1 floating point, 2 load/store and 3 branch. At most 4, 2, 3 and 1 instructions of these classes are granted per cycle. An entry whose class is already full ends its context's issue.
- R4: No more than 8 instructions are granted in one cycle across all contexts.
- R5: Priority is fixed, with context 0 highest. A context receives slots and class capacity only after every higher-priority context has taken what it can.
- R6: With policy code 0 (single context), only the highest-priority context whose entry 0 is ready issues. If no context has entry 0 ready, nothing is granted.
- R7: With policy code 1 (shared, uncapped), a context may take up to all 8 slots. Codes 6 and 7 behave as code 1.
- R8: Policy codes 2, 3 and 4 cap each context at 1, 2 and 4 granted instructions per cycle.
- R9: With policy code 5 (class binding), context t issues only instructions whose class equals bind bits [2t+1:2t]. Its first entry of another class ends its issue.
- R10: Slots are filled from slot 0 upward with no gaps, in visiting order (context ascending, then entry ascending). Each valid slot is tagged with its context, entry and class. Unused slots have valid 0 and all tags 0.
- R11: Outputs change only at a rising clock edge, and they show the allocation for the inputs sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 3 | Issue policy code |
| rdy_i | input | 64 | Ready bit per window entry; bit t*8+e is context t, entry e |
| cls_i | input | 128 | Unit class per window entry; bits [2i+1:2i] belong to entry i |
| bind_i | input | 16 | Bound class per context for policy 5 |
| grant_o | output | 64 | Registered grant bit per window entry |
| slot_vld_o | output | 8 | Slot occupied |
| slot_tid_o | output | 24 | Context id per slot, 3 bits each |
| slot_ent_o | output | 24 | Window entry per slot, 3 bits each |
| slot_cls_o | output | 16 | Unit class per slot, 2 bits each |

## Verification
The assertions assume that every input is driven to a known value at each rising edge after reset. They also assume that a ready bit describes an instruction actually in the window, so ready bits beyond the real window contents are presented as 0. The stimulus changes inputs only at falling edges and always drives every input to a defined value. Ready bits are drawn mostly set so that the class, width and cap limits are actually reached, and all eight policy codes are used, including the two spare codes.

// File: rtl/smt_issue_pkg.sv
package smt_issue_pkg;

  localparam logic [2:0] POL_SINGLE = 3'd0;
  localparam logic [2:0] POL_SHARED = 3'd1;
  localparam logic [2:0] POL_CAP1   = 3'd2;
  localparam logic [2:0] POL_CAP2   = 3'd3;
  localparam logic [2:0] POL_CAP4   = 3'd4;
  localparam logic [2:0] POL_BOUND  = 3'd5;

  localparam int CLS_W   = 2;
  localparam int NUM_CLS = 4;

  // Per-context issue limit for a policy; width is the full slot count.
  function automatic int policy_cap(input logic [2:0] pol, input int width);
    case (pol)
      POL_CAP1: policy_cap = 1;
      POL_CAP2: policy_cap = 2;
      POL_CAP4: policy_cap = 4;
      default:  policy_cap = width;
    endcase
  endfunction

  // Units available for a class in one cycle.
  function automatic int class_room(input logic [1:0] c, input int n_int,
                                    input int n_fp, input int n_ls, input int n_br);
    case (c)
      2'd0:    class_room = n_int;
      2'd1:    class_room = n_fp;
      2'd2:    class_room = n_ls;
      default: class_room = n_br;
    endcase
  endfunction

endpackage

// File: rtl/smt_policy_decode.sv
module smt_policy_decode
  import smt_issue_pkg::*;
#(
  parameter int ISSUE_W = 8
) (
  input  logic [2:0]                     mode_i,
  output logic [$clog2(ISSUE_W+1)-1:0]   cap_o,
  output logic                           single_o,
  output logic                           bound_o
);
  localparam int CW = $clog2(ISSUE_W+1);

  always_comb begin
    cap_o    = CW'(policy_cap(mode_i, ISSUE_W));
    single_o = (mode_i == POL_SINGLE);
    bound_o  = (mode_i == POL_BOUND);
  end
endmodule

// File: rtl/smt_issue_scan.sv
module smt_issue_scan
  import smt_issue_pkg::*;
#(
  parameter int NTHR    = 8,
  parameter int WIN     = 8,
  parameter int ISSUE_W = 8,
  parameter int N_INT   = 4,
  parameter int N_FP    = 2,
  parameter int N_LS    = 3,
  parameter int N_BR    = 1
) (
  input  logic [NTHR*WIN-1:0]          rdy_i,
  input  logic [NTHR*WIN*CLS_W-1:0]    cls_i,
  input  logic [NTHR*CLS_W-1:0]        bind_i,
  input  logic [$clog2(ISSUE_W+1)-1:0] cap_i,
  input  logic                         single_i,
  input  logic                         bound_i,
  output logic [NTHR*WIN-1:0]          grant_o
);
  // Sequential visit in priority order; the loop unrolls into a chain of
  // NTHR*WIN compare stages.
  always_comb begin
    int used [NUM_CLS];
    int total;
    int tcnt;
    logic taken;
    logic stop;
    logic [1:0] c;
    grant_o = '0;
    total   = 0;
    taken   = 1'b0;
    for (int k = 0; k < NUM_CLS; k++) used[k] = 0;
    for (int t = 0; t < NTHR; t++) begin
      tcnt = 0;
      stop = single_i && (taken || !rdy_i[t*WIN]);
      for (int e = 0; e < WIN; e++) begin
        c = cls_i[(t*WIN+e)*CLS_W +: CLS_W];
        if (!stop) begin
          if (rdy_i[t*WIN+e] && (total < ISSUE_W) && (tcnt < int'(cap_i)) &&
              (used[c] < class_room(c, N_INT, N_FP, N_LS, N_BR)) &&
              (!bound_i || (c == bind_i[t*CLS_W +: CLS_W]))) begin
            grant_o[t*WIN+e] = 1'b1;
            used[c] = used[c] + 1;
            total   = total + 1;
            tcnt    = tcnt + 1;
          end else begin
            stop = 1'b1;
          end
        end
      end
      if (single_i && (tcnt != 0)) taken = 1'b1;
    end
  end
endmodule

// File: rtl/smt_slot_pack.sv
module smt_slot_pack
  import smt_issue_pkg::*;
#(
  parameter int NTHR    = 8,
  parameter int WIN     = 8,
  parameter int ISSUE_W = 8
) (
  input  logic [NTHR*WIN-1:0]              grant_i,
  input  logic [NTHR*WIN*CLS_W-1:0]        cls_i,
  output logic [ISSUE_W-1:0]               vld_o,
  output logic [ISSUE_W*$clog2(NTHR)-1:0]  tid_o,
  output logic [ISSUE_W*$clog2(WIN)-1:0]   ent_o,
  output logic [ISSUE_W*CLS_W-1:0]         cls_o
);
  localparam int TW = $clog2(NTHR);
  localparam int EW = $clog2(WIN);

  always_comb begin
    int n;
    vld_o = '0;
    tid_o = '0;
    ent_o = '0;
    cls_o = '0;
    n = 0;
    for (int t = 0; t < NTHR; t++) begin
      for (int e = 0; e < WIN; e++) begin
        if (grant_i[t*WIN+e] && (n < ISSUE_W)) begin
          vld_o[n]              = 1'b1;
          tid_o[n*TW +: TW]     = TW'(t);
          ent_o[n*EW +: EW]     = EW'(e);
          cls_o[n*CLS_W +: CLS_W] = cls_i[(t*WIN+e)*CLS_W +: CLS_W];
          n = n + 1;
        end
      end
    end
  end
endmodule

// File: rtl/smt_issue_alloc.sv
module smt_issue_alloc
  import smt_issue_pkg::*;
#(
  parameter int NTHR    = 8,
  parameter int WIN     = 8,
  parameter int ISSUE_W = 8,
  parameter int N_INT   = 4,
  parameter int N_FP    = 2,
  parameter int N_LS    = 3,
  parameter int N_BR    = 1
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [2:0]                          mode_i,
  input  logic [NTHR*WIN-1:0]                 rdy_i,
  input  logic [NTHR*WIN*CLS_W-1:0]           cls_i,
  input  logic [NTHR*CLS_W-1:0]               bind_i,
  output logic [NTHR*WIN-1:0]                 grant_o,
  output logic [ISSUE_W-1:0]                  slot_vld_o,
  output logic [ISSUE_W*$clog2(NTHR)-1:0]     slot_tid_o,
  output logic [ISSUE_W*$clog2(WIN)-1:0]      slot_ent_o,
  output logic [ISSUE_W*CLS_W-1:0]            slot_cls_o
);
  localparam int TW = $clog2(NTHR);
  localparam int EW = $clog2(WIN);
  localparam int CW = $clog2(ISSUE_W+1);

  logic [CW-1:0]               cap_w;
  logic                        single_w;
  logic                        bound_w;
  logic [NTHR*WIN-1:0]         grant_w;
  logic [ISSUE_W-1:0]          vld_w;
  logic [ISSUE_W*TW-1:0]       tid_w;
  logic [ISSUE_W*EW-1:0]       ent_w;
  logic [ISSUE_W*CLS_W-1:0]    scls_w;

  smt_policy_decode #(.ISSUE_W(ISSUE_W)) u_pol (
    .mode_i  (mode_i),
    .cap_o   (cap_w),
    .single_o(single_w),
    .bound_o (bound_w)
  );

  smt_issue_scan #(
    .NTHR(NTHR), .WIN(WIN), .ISSUE_W(ISSUE_W),
    .N_INT(N_INT), .N_FP(N_FP), .N_LS(N_LS), .N_BR(N_BR)
  ) u_scan (
    .rdy_i   (rdy_i),
    .cls_i   (cls_i),
    .bind_i  (bind_i),
    .cap_i   (cap_w),
    .single_i(single_w),
    .bound_i (bound_w),
    .grant_o (grant_w)
  );

  smt_slot_pack #(.NTHR(NTHR), .WIN(WIN), .ISSUE_W(ISSUE_W)) u_pack (
    .grant_i(grant_w),
    .cls_i  (cls_i),
    .vld_o  (vld_w),
    .tid_o  (tid_w),
    .ent_o  (ent_w),
    .cls_o  (scls_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_o    <= '0;
      slot_vld_o <= '0;
      slot_tid_o <= '0;
      slot_ent_o <= '0;
      slot_cls_o <= '0;
    end else begin
      grant_o    <= grant_w;
      slot_vld_o <= vld_w;
      slot_tid_o <= tid_w;
      slot_ent_o <= ent_w;
      slot_cls_o <= scls_w;
    end
  end

  // ---------------- assertion helpers ----------------
  function automatic int slots_of_class(input logic [ISSUE_W-1:0] v,
                                        input logic [ISSUE_W*CLS_W-1:0] c,
                                        input logic [1:0] k);
    int n = 0;
    for (int s = 0; s < ISSUE_W; s++)
      if (v[s] && (c[s*CLS_W +: CLS_W] == k)) n++;
    return n;
  endfunction

  function automatic logic [1:0] bound_class(input logic [NTHR*CLS_W-1:0] b,
                                             input logic [TW-1:0] t);
    return b[t*CLS_W +: CLS_W];
  endfunction

  logic [NTHR-1:0] thr_any;
  for (genvar t = 0; t < NTHR; t++) begin : g_any
    assign thr_any[t] = |grant_o[t*WIN +: WIN];
  end

  p_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(grant_o) <= ISSUE_W);

  p_slot_count_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(slot_vld_o) == $countones(grant_o));

  p_single_ctx_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(single_w) |-> $onehot0(thr_any));

  for (genvar i = 0; i < NTHR*WIN; i++) begin : g_gr
    p_grant_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
      grant_o[i] |-> $past(rdy_i[i]));
  end

  for (genvar t = 0; t < NTHR; t++) begin : g_thr
    p_thread_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(grant_o[t*WIN +: WIN]) <= int'($past(cap_w)));
    for (genvar e = 1; e < WIN; e++) begin : g_ord
      p_in_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
        grant_o[t*WIN+e] |-> grant_o[t*WIN+e-1]);
    end
  end

  for (genvar k = 0; k < NUM_CLS; k++) begin : g_cls
    p_class_room_r3: assert property (@(posedge clk) disable iff (!rst_n)
      slots_of_class(slot_vld_o, slot_cls_o, 2'(k)) <=
        class_room(2'(k), N_INT, N_FP, N_LS, N_BR));
  end

  for (genvar s = 0; s < ISSUE_W; s++) begin : g_slot
    if (s > 0) begin : g_contig
      p_slot_contig_r10: assert property (@(posedge clk) disable iff (!rst_n)
        slot_vld_o[s] |-> slot_vld_o[s-1]);
    end
    p_bound_class_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_vld_o[s] && $past(bound_w)) |->
        (slot_cls_o[s*CLS_W +: CLS_W] ==
         bound_class($past(bind_i), slot_tid_o[s*TW +: TW])));
  end

endmodule

// File: tb/smt_issue_alloc_tb.sv
`timescale 1ns/1ps
module smt_issue_alloc_tb;
  localparam int NT = 8;
  localparam int NW = 8;
  localparam int IW = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [2:0]   mode;
  logic [63:0]  rdy;
  logic [127:0] cls;
  logic [15:0]  bnd;
  logic [63:0]  grant;
  logic [7:0]   svld;
  logic [23:0]  stid;
  logic [23:0]  sent;
  logic [15:0]  scls;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [63:0] e_g;
  logic [7:0]  e_v;
  logic [23:0] e_t, e_e;
  logic [15:0] e_c;

  always #2 clk = ~clk;

  smt_issue_alloc u_dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .rdy_i(rdy), .cls_i(cls),
    .bind_i(bnd), .grant_o(grant), .slot_vld_o(svld), .slot_tid_o(stid),
    .slot_ent_o(sent), .slot_cls_o(scls)
  );

  // Reference allocation, written from the requirements.
  function automatic void model(input logic [2:0] m, input logic [63:0] r,
      input logic [127:0] c, input logic [15:0] b,
      output logic [63:0] g, output logic [7:0] v,
      output logic [23:0] tid, output logic [23:0] ent, output logic [15:0] sc);
    int room [4];
    int left, lim, k, e, took, idx;
    logic [1:0] cc;
    bit someone;
    room[0] = 4; room[1] = 2; room[2] = 3; room[3] = 1;
    g = '0; v = '0; tid = '0; ent = '0; sc = '0;
    left = IW; k = 0; someone = 0;
    lim = (m == 3'd2) ? 1 : (m == 3'd3) ? 2 : (m == 3'd4) ? 4 : IW;
    for (int t = 0; t < NT; t++) begin
      if (m == 3'd0 && (someone || !r[t*NW])) continue;
      e = 0; took = 0;
      while (e < NW && took < lim && left > 0) begin
        idx = t*NW + e;
        cc  = c[idx*2 +: 2];
        if (!r[idx] || room[cc] == 0 || (m == 3'd5 && cc != b[t*2 +: 2])) break;
        g[idx] = 1'b1;
        room[cc]--; left--; took++;
        v[k] = 1'b1;
        tid[k*3 +: 3] = 3'(t);
        ent[k*3 +: 3] = 3'(e);
        sc[k*2 +: 2]  = cc;
        k++; e++;
      end
      if (took > 0) someone = 1;
    end
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_outputs(input string req);
    chk(req, grant, e_g);
    chk("R10 slot valid", {56'd0, svld}, {56'd0, e_v});
    chk("R10 slot tid",   {40'd0, stid}, {40'd0, e_t});
    chk("R10 slot entry", {40'd0, sent}, {40'd0, e_e});
    chk("R10 slot class", {48'd0, scls}, {48'd0, e_c});
  endtask

  // Drive at a falling edge, compare one falling edge later (one register).
  task automatic apply(input logic [2:0] m, input logic [63:0] r,
                       input logic [127:0] c, input logic [15:0] b, input string req);
    @(negedge clk);
    mode = m; rdy = r; cls = c; bnd = b;
    model(m, r, c, b, e_g, e_v, e_t, e_e, e_c);
    @(negedge clk);
    check_outputs(req);
  endtask

  function automatic logic [127:0] cls_fill(input logic [1:0] k);
    logic [127:0] x;
    for (int i = 0; i < 64; i++) x[i*2 +: 2] = k;
    return x;
  endfunction

  function automatic logic [127:0] cls_cycle();
    logic [127:0] x;
    for (int i = 0; i < 64; i++) x[i*2 +: 2] = 2'(i % 4);
    return x;
  endfunction

  initial begin
    #(4*200000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] r;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; mode = 3'd1; rdy = '1; cls = '0; bnd = '0;
    repeat (3) @(negedge clk);
    // R1: outputs held clear under reset with active inputs
    chk("R1 grant in reset", grant, 64'd0);
    chk("R1 slots in reset", {40'd0, svld, stid}, 64'd0);
    rst_n = 1'b1;
    rdy = '0;
    @(negedge clk);
    chk("R1 grant after reset", grant, 64'd0);

    // R3: all integer, shared: only four granted, thread 0
    apply(3'd1, '1, cls_fill(2'd0), '0, "R3 integer room");
    chk("R3 grant count", 64'(($countones(grant))), 64'd4);
    // R4/R5/R7: mixed classes, uncapped
    apply(3'd1, '1, cls_cycle(), '0, "R7 uncapped");
    chk("R4 total", 64'($countones(grant)), 64'd8);
    chk("R5 thread0 first", {56'd0, grant[7:0]}, 64'h7f);
    // R2: gap in readiness
    apply(3'd1, 64'hffff_ffff_ffff_fffd, cls_cycle(), '0, "R2 in order");
    // R8: caps
    apply(3'd2, '1, cls_cycle(), '0, "R8 cap one");
    apply(3'd3, '1, cls_cycle(), '0, "R8 cap two");
    apply(3'd4, '1, cls_cycle(), '0, "R8 cap four");
    // R6: single context
    apply(3'd0, 64'hffff_ffff_fff0_ff00, cls_cycle(), '0, "R6 single pick");
    apply(3'd0, 64'hfefe_fefe_fefe_fefe, cls_cycle(), '0, "R6 idle");
    chk("R6 nothing granted", grant, 64'd0);
    // R9: class binding
    apply(3'd5, '1, cls_fill(2'd2), 16'haaaa, "R9 bound load/store");
    apply(3'd5, '1, cls_cycle(), 16'h1b1b, "R9 bound mixed");
    // R7: spare codes
    apply(3'd6, '1, cls_cycle(), '0, "R7 spare code 6");
    apply(3'd7, 64'h0f0f_0f0f_0f0f_0f0f, cls_fill(2'd1), '0, "R7 spare code 7");
    // R11: output holds between edges
    @(negedge clk);
    mode = 3'd2; rdy = '0; cls = cls_fill(2'd3); bnd = '1;
    #1;
    check_outputs("R11 hold before edge");
    model(mode, rdy, cls, bnd, e_g, e_v, e_t, e_e, e_c);
    @(negedge clk);
    check_outputs("R11 after edge");

    for (int it = 0; it < 400; it++) begin
      logic [2:0] m;
      logic [127:0] c;
      string tag;
      r = ~({$urandom, $urandom} & {$urandom, $urandom});
      c = {$urandom, $urandom, $urandom, $urandom};
      m = 3'($urandom % 8);
      case (m)
        3'd0:           tag = "R6 random";
        3'd5:           tag = "R9 random";
        3'd2, 3'd3, 3'd4: tag = "R8 random";
        default:        tag = "R7 random";
      endcase
      apply(m, r, c, 16'($urandom), tag);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule